// File: doc/BRIEF.md
# Dual Cache Control Register Unit

This unit holds the software-visible controls for a split instruction and data cache. One 32-bit control word carries, for each cache, stored levels (enable, freeze, burst enable, plus a write-allocate policy level for the data side) and two one-shot commands: invalidate the whole cache, or invalidate one line. The line for the single-line command comes from the index field of a second 32-bit register, the entry address register. The unit turns these commands into one-cycle invalidation strobes towards the cache arrays, and it drives the stored levels as steady control outputs.

Software reaches both registers through a one-cycle request port. `req_sel` picks the control word (0) or the entry address register (1). A write takes effect on the clock edge that samples it. A read answers with `rsp_valid` and `rsp_rdata` in the following cycle. A hardware reset clears every stored level and raises both whole-cache strobes, so the valid bits of both caches are wiped.

Top module: `ccr_unit`

## Requirements
- R1: While `rst` is high, after a clock edge, all levels (`ic_enable`, `ic_freeze`, `ic_burst`, `dc_enable`, `dc_freeze`, `dc_burst`, `dc_write_alloc`) are 0, `ic_inval_all` and `dc_inval_all` are 1, both single-line strobes and `rsp_valid` are 0, and the entry address register and both index outputs are 0. The whole-cache strobes drop in the first cycle after reset unless a write asks for them.
- R2: Instruction levels sit in the control word at bit 0 (enable), bit 1 (freeze) and bit 4 (burst enable). A control write stores them, and they appear on the outputs in the cycle after the write.
- R3: Data levels sit at bit 8 (enable), bit 9 (freeze), bit 12 (burst enable) and bit 13 (write allocate). They behave like R2.
- R4: Bits 31:14 and 7:5 of the control word always read as 0, and writing them changes no output.
- R5: Bit 3 (instruction) and bit 11 (data) of a control write each raise their cache's whole-cache strobe for exactly one cycle, the cycle after the write. These bits always read back as 0.
- R6: Bit 2 (instruction) and bit 10 (data) each raise their cache's single-line strobe for one cycle after the write. At the same time the index output carries bits [IDX_LSB+IDX_W-1:IDX_LSB] of the entry address register as it stood before that write. The index output keeps its value between strobes. These bits read back as 0.
- R7: When a single write sets both the whole-cache bit and the single-line bit of one cache, only that cache's whole-cache strobe fires.
- R8: The two caches act independently. A single write may command both in the same cycle, and a command bit for one cache never raises a strobe of the other.
- R9: Address 1 is a full 32-bit read/write entry address register. Writing it changes no control output.
- R10: A read returns `rsp_valid` = 1 and the register value in the cycle after the request. `rsp_valid` is 0 in every other cycle. Cycles without a write leave all levels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = control word, 1 = entry address register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| ic_enable | output | 1 | Instruction cache enable level |
| ic_freeze | output | 1 | Instruction cache freeze level |
| ic_burst | output | 1 | Instruction burst-fill enable level |
| ic_inval_all | output | 1 | Invalidate whole instruction cache (strobe) |
| ic_inval_one | output | 1 | Invalidate one instruction line (strobe) |
| ic_inval_idx | output | IDX_W | Line index for `ic_inval_one` |
| dc_enable | output | 1 | Data cache enable level |
| dc_freeze | output | 1 | Data cache freeze level |
| dc_burst | output | 1 | Data burst-fill enable level |
| dc_write_alloc | output | 1 | Data write-allocate policy level |
| dc_inval_all | output | 1 | Invalidate whole data cache (strobe) |
| dc_inval_one | output | 1 | Invalidate one data line (strobe) |
| dc_inval_idx | output | IDX_W | Line index for `dc_inval_one` |

## Verification
A single control write can carry a whole-cache command and a single-line command for the same cache. It can also carry commands for both caches in the same cycle. The bench provokes these cases with directed writes, and also with random 32-bit write data, where each command bit is set half the time, so every combination turns up often. A reference model computed in the bench judges each cycle. For each cache it expects the whole-cache strobe to win over the single-line strobe, with no cross-talk between caches. It also expects the index to come from the entry address register as it stood before the write.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LANES   = 2;
  localparam int unsigned LANE_SP = 8;   // bit distance between lane fields
  localparam int unsigned WA_BIT  = 13;

  // Command/level field of one cache, in bit order of the control word
  typedef struct packed {
    logic burst;
    logic clr;
    logic clr_one;
    logic freeze;
    logic enable;
  } lane_cmd_t;

  typedef struct packed {
    logic burst;
    logic freeze;
    logic enable;
  } lane_lvl_t;

  localparam logic [WORD_W-1:0] RSVD_MASK = 32'hFFFF_C0E0;

  function automatic logic [WORD_W-1:0] place_lane(input lane_lvl_t l, input int unsigned lsb);
    logic [WORD_W-1:0] v;
    v = '0;
    v[lsb]     = l.enable;
    v[lsb + 1] = l.freeze;
    v[lsb + 4] = l.burst;
    return v;
  endfunction
endpackage

// File: rtl/cc_lane.sv
module cc_lane
  import ccr_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  lane_cmd_t        cmd,
  input  logic [IDX_W-1:0] sel_idx,
  output lane_lvl_t        lvl,
  output logic             inv_all,
  output logic             inv_one,
  output logic [IDX_W-1:0] inv_idx
);
  logic one_req;
  assign one_req = wr && cmd.clr_one && !cmd.clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl     <= '0;
      inv_all <= 1'b1;
      inv_one <= 1'b0;
      inv_idx <= '0;
    end else begin
      inv_all <= wr && cmd.clr;
      inv_one <= one_req;
      if (wr) begin
        lvl.enable <= cmd.enable;
        lvl.freeze <= cmd.freeze;
        lvl.burst  <= cmd.burst;
      end
      if (one_req) inv_idx <= sel_idx;
    end
  end

  p_inv_cause_r5: assert property (@(posedge clk) disable iff (rst)
    inv_all |-> ($past(rst) || $past(wr && cmd.clr)));
  p_inv_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(inv_all && inv_one));
  p_one_cause_r6: assert property (@(posedge clk) disable iff (rst)
    inv_one |-> $past(wr && cmd.clr_one));
  p_one_idx_r6: assert property (@(posedge clk) disable iff (rst)
    inv_one |-> (inv_idx == $past(sel_idx)));
  p_lvl_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(lvl));
endmodule

// File: rtl/cc_addr_reg.sv
module cc_addr_reg #(
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned IDX_LSB = 4,
  parameter int unsigned IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (wr) q <= wdata;
  end
  assign idx = q[IDX_LSB +: IDX_W];

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(q));
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned IDX_LSB = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_sel,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic             ic_enable,
  output logic             ic_freeze,
  output logic             ic_burst,
  output logic             ic_inval_all,
  output logic             ic_inval_one,
  output logic [IDX_W-1:0] ic_inval_idx,
  output logic             dc_enable,
  output logic             dc_freeze,
  output logic             dc_burst,
  output logic             dc_write_alloc,
  output logic             dc_inval_all,
  output logic             dc_inval_one,
  output logic [IDX_W-1:0] dc_inval_idx
);
  localparam int unsigned CMD_W = $bits(lane_cmd_t);

  logic              wr_ctl, wr_adr, rd_req;
  logic [WORD_W-1:0] adr_q;
  logic [IDX_W-1:0]  adr_idx;
  logic              walloc_q;
  lane_lvl_t         lvl     [LANES];
  logic              inv_all [LANES];
  logic              inv_one [LANES];
  logic [IDX_W-1:0]  inv_idx [LANES];
  logic [WORD_W-1:0] ctl_view;

  assign wr_ctl = req_valid && req_write && !req_sel;
  assign wr_adr = req_valid && req_write &&  req_sel;
  assign rd_req = req_valid && !req_write;

  cc_addr_reg #(.WIDTH(WORD_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_adr (
    .clk(clk), .rst(rst), .wr(wr_adr), .wdata(req_wdata), .q(adr_q), .idx(adr_idx)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned LSB = g * LANE_SP;
    cc_lane #(.IDX_W(IDX_W)) u_lane (
      .clk(clk), .rst(rst), .wr(wr_ctl),
      .cmd(lane_cmd_t'(req_wdata[LSB +: CMD_W])),
      .sel_idx(adr_idx),
      .lvl(lvl[g]), .inv_all(inv_all[g]), .inv_one(inv_one[g]), .inv_idx(inv_idx[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)         walloc_q <= 1'b0;
    else if (wr_ctl) walloc_q <= req_wdata[WA_BIT];
  end

  always_comb begin
    ctl_view = place_lane(lvl[0], 0) | place_lane(lvl[1], LANE_SP);
    ctl_view[WA_BIT] = walloc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= req_sel ? adr_q : ctl_view;
    end
  end

  assign ic_enable      = lvl[0].enable;
  assign ic_freeze      = lvl[0].freeze;
  assign ic_burst       = lvl[0].burst;
  assign ic_inval_all   = inv_all[0];
  assign ic_inval_one   = inv_one[0];
  assign ic_inval_idx   = inv_idx[0];
  assign dc_enable      = lvl[1].enable;
  assign dc_freeze      = lvl[1].freeze;
  assign dc_burst       = lvl[1].burst;
  assign dc_write_alloc = walloc_q;
  assign dc_inval_all   = inv_all[1];
  assign dc_inval_one   = inv_one[1];
  assign dc_inval_idx   = inv_idx[1];

  p_rsp_cause_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write));
  p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(!req_sel)) |-> ((rsp_rdata & RSVD_MASK) == '0));
  p_walloc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_ctl |=> $stable(dc_write_alloc));
endmodule

// File: tb/sim_ccr_unit.sv
`timescale 1ns/1ps
module sim_ccr_unit;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned IDX_LSB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_sel = 1'b0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic ic_enable, ic_freeze, ic_burst, ic_inval_all, ic_inval_one;
  logic dc_enable, dc_freeze, dc_burst, dc_write_alloc, dc_inval_all, dc_inval_one;
  logic [IDX_W-1:0] ic_inval_idx, dc_inval_idx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] m_ctl;   // stored levels in control-word positions
  logic [31:0] m_adr;
  logic [IDX_W-1:0] m_iidx, m_didx;

  always #4 clk = ~clk;

  ccr_unit #(.IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ic_enable(ic_enable), .ic_freeze(ic_freeze), .ic_burst(ic_burst),
    .ic_inval_all(ic_inval_all), .ic_inval_one(ic_inval_one), .ic_inval_idx(ic_inval_idx),
    .dc_enable(dc_enable), .dc_freeze(dc_freeze), .dc_burst(dc_burst),
    .dc_write_alloc(dc_write_alloc), .dc_inval_all(dc_inval_all),
    .dc_inval_one(dc_inval_one), .dc_inval_idx(dc_inval_idx)
  );

  function automatic logic [31:0] level_bits(input logic [31:0] d);
    return d & 32'h0000_3313;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_levels();
    chk("R2 ic_enable", 32'(ic_enable), 32'(m_ctl[0]));
    chk("R2 ic_freeze", 32'(ic_freeze), 32'(m_ctl[1]));
    chk("R2 ic_burst",  32'(ic_burst),  32'(m_ctl[4]));
    chk("R3 dc_enable", 32'(dc_enable), 32'(m_ctl[8]));
    chk("R3 dc_freeze", 32'(dc_freeze), 32'(m_ctl[9]));
    chk("R3 dc_burst",  32'(dc_burst),  32'(m_ctl[12]));
    chk("R3 dc_write_alloc", 32'(dc_write_alloc), 32'(m_ctl[13]));
  endtask

  // one access (or idle), checked one cycle later
  task automatic op(input bit v, input bit w, input bit s, input logic [31:0] d);
    bit e_iall, e_ione, e_dall, e_done, e_rv;
    logic [31:0] e_rd;
    logic [IDX_W-1:0] old_idx;
    @(negedge clk);
    req_valid = v; req_write = w; req_sel = s; req_wdata = d;
    old_idx = m_adr[IDX_LSB +: IDX_W];
    e_iall = v && w && !s && d[3];
    e_ione = v && w && !s && d[2] && !d[3];
    e_dall = v && w && !s && d[11];
    e_done = v && w && !s && d[10] && !d[11];
    e_rv   = v && !w;
    e_rd   = s ? m_adr : m_ctl;
    if (v && w && !s) m_ctl = level_bits(d);
    if (v && w && s)  m_adr = d;
    if (e_ione) m_iidx = old_idx;
    if (e_done) m_didx = old_idx;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5 ic_inval_all", 32'(ic_inval_all), 32'(e_iall));
    chk("R8 dc_inval_all", 32'(dc_inval_all), 32'(e_dall));
    chk("R7 ic_inval_one", 32'(ic_inval_one), 32'(e_ione));
    chk("R7 dc_inval_one", 32'(dc_inval_one), 32'(e_done));
    chk("R6 ic_inval_idx", 32'(ic_inval_idx), 32'(m_iidx));
    chk("R6 dc_inval_idx", 32'(dc_inval_idx), 32'(m_didx));
    chk("R10 rsp_valid", 32'(rsp_valid), 32'(e_rv));
    if (e_rv) chk(s ? "R9 read adr" : "R4 read ctl", rsp_rdata, e_rd);
    check_levels();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    m_ctl = '0; m_adr = '0; m_iidx = '0; m_didx = '0;
    chk("R1 ic_inval_all", 32'(ic_inval_all), 32'd1);
    chk("R1 dc_inval_all", 32'(dc_inval_all), 32'd1);
    chk("R1 inval_one", 32'({ic_inval_one, dc_inval_one}), 32'd0);
    chk("R1 idx", 32'({ic_inval_idx, dc_inval_idx}), 32'd0);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check_levels();
    rst = 1'b0;
    op(1'b0, 1'b0, 1'b0, '0);   // R1: strobes drop after reset
    op(1'b1, 1'b0, 1'b1, '0);   // R1: address register reads zero
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_ctl = '0; m_adr = '0; m_iidx = '0; m_didx = '0;
    do_reset();
    // R2/R3 directed levels and readback
    op(1'b1, 1'b1, 1'b0, 32'h0000_3313);
    op(1'b1, 1'b0, 1'b0, '0);
    op(1'b1, 1'b1, 1'b0, 32'h0000_0201);
    op(1'b1, 1'b0, 1'b0, '0);
    // R4 reserved bits only: levels all cleared, read zero
    op(1'b1, 1'b1, 1'b0, 32'hFFFF_C0E0);
    op(1'b1, 1'b0, 1'b0, '0);
    // R9 address register, no effect on controls
    op(1'b1, 1'b1, 1'b1, 32'hA5A5_5A7C);
    op(1'b1, 1'b0, 1'b1, '0);
    // R6 single-line strobes, index from address register
    op(1'b1, 1'b1, 1'b0, 32'h0000_0404);
    op(1'b0, 1'b0, 1'b0, '0);
    // R5/R8 clear-all both caches in one write, read back zero
    op(1'b1, 1'b1, 1'b0, 32'h0000_0808);
    op(1'b1, 1'b0, 1'b0, '0);
    // R7 both commands same cache, plus R8 other cache entry only
    op(1'b1, 1'b1, 1'b1, 32'h0000_0030);
    op(1'b1, 1'b1, 1'b0, 32'h0000_040C);
    op(1'b1, 1'b1, 1'b0, 32'h0000_0C04);
    // back-to-back strobes
    op(1'b1, 1'b1, 1'b0, 32'h0000_0808);
    op(1'b1, 1'b1, 1'b0, 32'h0000_0808);
    // R1 mid-run reset after setting levels
    op(1'b1, 1'b1, 1'b0, 32'h0000_3313);
    do_reset();
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      op(r[0] | r[1], r[2], r[3], $urandom);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule